// File: doc/BRIEF.md
# Auto-Ranging Reciprocal Measurement Controller

This block measures an unknown digital input against the local clock using two counters that share one gate window. An event counter tallies rising edges of the input, and a clock counter tallies cycles of the reference clock. The window opens on an input rising edge. Once a requested gate length has elapsed, it closes on the next input rising edge rather than at once. Because both ends of the window sit on input edges, the event count carries no ±1 gating error, and the clock count spans exactly that many whole input periods. The block performs no division. Downstream logic forms the frequency (events / clocks × fclk) or the period (clocks / events / fclk) from the raw pair.

Each measurement begins with a survey window of fixed length, during which input edges are tallied. If that tally falls below a threshold set at the square root of the reference frequency (1000 for 1 MHz over a one-second survey), the input counts as slow. The block then takes a short period-style gate, so the clock count carries the resolution. Otherwise it takes a long frequency-style gate, so the event count carries the resolution. The chosen mode travels with the results as a flag.

The sequencer has six states. IDLE waits for `start`. SURVEY counts edges for `PRE_WIN` cycles. ARM waits for the opening input edge. OPEN counts until the gate length is reached. HOLD waits for the closing input edge once the gate length has expired. REPORT presents the results for one cycle and returns to IDLE. Transitions: IDLE→SURVEY on start; SURVEY→ARM at the end of the survey window; ARM→OPEN on an input rising edge; OPEN→HOLD when the gate length is reached with no edge; OPEN→REPORT when the gate length is reached on an edge; HOLD→REPORT on an edge; REPORT→IDLE always.

Top module: `rc_auto_counter`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_events`, `res_clocks` and `res_slow` are all 0.
- R2: A `start` pulse seen in IDLE begins a survey window of exactly `PRE_WIN` clock cycles. A `start` seen in any other state is ignored and neither restarts nor delays the measurement in progress.
- R3: `res_slow` is 1 when the number of input rising edges counted in the survey window is below `THRESH`, and 0 otherwise.
- R4: The gate opens on an input rising edge. `res_events` is the number of input rising edges after the opening edge, up to and including the closing edge. `res_clocks` is the number of clock cycles over the same span, so for a periodic input of P cycles `res_clocks` = `res_events` × P exactly.
- R5: The gate length is `PER_GATE` cycles when slow and `FRQ_GATE` cycles otherwise. The gate closes on the first input rising edge at which at least that many cycles are in the window, so for period P, `res_events` = ceil(length / P).
- R6: `res_valid` is high for exactly one cycle per completed measurement. All three results change only in that cycle and hold their values until the next one.
- R7: Only rising input edges count. The high time of the input (duty cycle) does not change any result.
- R8: The input passes through `SYNC_STAGES` flip-flops before edge detection. A result is due no later than `PRE_WIN` + (`res_events` + 1) × P + `SYNC_STAGES` + 6 cycles after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the counted time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a measurement (acted on in IDLE only) |
| sig_in | input | 1 | Unknown input signal, asynchronous |
| res_valid | output | 1 | One-cycle strobe marking new results |
| res_events | output | CNT_W | Input rising edges inside the gate |
| res_clocks | output | CNT_W | Clock cycles inside the gate |
| res_slow | output | 1 | 1 when period-style gating was chosen |

## Verification
The results and `res_valid` are due in the same cycle: the REPORT cycle, one clock after the closing edge reaches the sequencer. That edge itself lags the pin by `SYNC_STAGES` + 1 cycles. The bench therefore never predicts an absolute arrival cycle. It waits for the strobe, sampling on the falling clock edge, and checks the counts against ceil(length / P) and × P, along with the start-to-result bound of R8. On every other clock it checks that the strobe is not repeated and that the results have not moved since the last strobe.

// File: rtl/rc_pkg.sv
package rc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SURVEY,
        ST_ARM,
        ST_OPEN,
        ST_HOLD,
        ST_REPORT
    } rc_state_t;
endpackage

// File: rtl/rc_rise.sv
module rc_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;

    // R7
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/rc_tally.sv
module rc_tally #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic [W-1:0] q_nx
);
    assign q_nx = q + W'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= q_nx;
    end
endmodule

// File: rtl/rc_auto_counter.sv
module rc_auto_counter #(
    parameter int PRE_WIN     = 1000000,
    parameter int THRESH      = 1000,
    parameter int FRQ_GATE    = 1000000,
    parameter int PER_GATE    = 1,
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sig_in,
    output logic             res_valid,
    output logic [CNT_W-1:0] res_events,
    output logic [CNT_W-1:0] res_clocks,
    output logic             res_slow
);
    import rc_pkg::*;

    localparam logic [CNT_W-1:0] PRE_W = CNT_W'(PRE_WIN);
    localparam logic [CNT_W-1:0] THR_W = CNT_W'(THRESH);
    localparam logic [CNT_W-1:0] FRQ_W = CNT_W'(FRQ_GATE);
    localparam logic [CNT_W-1:0] PER_W = CNT_W'(PER_GATE);

    rc_state_t        state, nstate;
    logic             rise;
    logic             slow_q;
    logic             cnt_clr, cnt_run;
    logic             survey_end, gate_reached;
    logic [CNT_W-1:0] ev_q, ev_nx, ck_q, ck_nx;
    logic [CNT_W-1:0] gate_len;

    rc_rise #(.STAGES(SYNC_STAGES)) u_rise (
        .clk (clk),
        .rst_n(rst_n),
        .din (sig_in),
        .rise(rise)
    );

    rc_tally #(.W(CNT_W)) u_events (
        .clk (clk),
        .rst_n(rst_n),
        .clr (cnt_clr),
        .inc (cnt_run & rise),
        .q   (ev_q),
        .q_nx(ev_nx)
    );

    rc_tally #(.W(CNT_W)) u_clocks (
        .clk (clk),
        .rst_n(rst_n),
        .clr (cnt_clr),
        .inc (cnt_run),
        .q   (ck_q),
        .q_nx(ck_nx)
    );

    assign gate_len     = slow_q ? PER_W : FRQ_W;
    assign survey_end   = (state == ST_SURVEY) && (ck_nx >= PRE_W);
    assign gate_reached = ck_nx >= gate_len;
    assign cnt_run      = (state == ST_SURVEY) || (state == ST_OPEN) || (state == ST_HOLD);
    assign cnt_clr      = (state == ST_IDLE) || (state == ST_ARM) || survey_end;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (start) nstate = ST_SURVEY;
            ST_SURVEY: if (survey_end) nstate = ST_ARM;
            ST_ARM:    if (rise) nstate = ST_OPEN;
            ST_OPEN: begin
                if (gate_reached && rise) nstate = ST_REPORT;
                else if (gate_reached)    nstate = ST_HOLD;
            end
            ST_HOLD:   if (rise) nstate = ST_REPORT;
            ST_REPORT: nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slow_q     <= 1'b0;
            res_valid  <= 1'b0;
            res_events <= '0;
            res_clocks <= '0;
            res_slow   <= 1'b0;
        end else begin
            res_valid <= (nstate == ST_REPORT);
            if (survey_end)
                slow_q <= (ev_nx < THR_W);
            if (nstate == ST_REPORT) begin
                res_events <= ev_nx;
                res_clocks <= ck_nx;
                res_slow   <= slow_q;
            end
        end
    end

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_events) && $stable(res_clocks) && $stable(res_slow)));

    // R5
    gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_clocks >= (res_slow ? PER_W : FRQ_W)));

    // R4
    events_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((res_events != '0) && (res_events <= res_clocks)));

    // R2
    survey_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SURVEY) |-> (ck_q < PRE_W));

    // R2
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN || state == ST_HOLD) |=> (state != ST_SURVEY));
endmodule

// File: tb/sim_rc_auto_counter.sv
module sim_rc_auto_counter;
    localparam int PRE_WIN  = 400;
    localparam int THRESH   = 10;
    localparam int FRQ_GATE = 300;
    localparam int PER_GATE = 1;
    localparam int CNT_W    = 16;
    localparam int SYNC     = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             sig_in = 1'b0;
    logic             res_valid;
    logic [CNT_W-1:0] res_events, res_clocks;
    logic             res_slow;

    int vectors = 0;
    int fails = 0;
    int gen_per = 20;
    int gen_hi = 10;
    int gen_ph = 0;
    int valid_seen = 0;
    bit monitor_on = 1'b0;
    bit finished = 1'b0;
    logic             prev_valid = 1'b0;
    logic [CNT_W-1:0] held_ev = '0, held_ck = '0;
    logic             held_slow = 1'b0;

    always #2 clk = ~clk;

    rc_auto_counter #(
        .PRE_WIN(PRE_WIN), .THRESH(THRESH), .FRQ_GATE(FRQ_GATE),
        .PER_GATE(PER_GATE), .CNT_W(CNT_W), .SYNC_STAGES(SYNC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .sig_in(sig_in),
        .res_valid(res_valid), .res_events(res_events),
        .res_clocks(res_clocks), .res_slow(res_slow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // input pattern generator, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            sig_in = (gen_ph < gen_hi);
            gen_ph = gen_ph + 1;
            if (gen_ph >= gen_per) gen_ph = 0;
        end
    end

    // per-clock reference comparison of strobe and held results (R6)
    initial begin
        forever begin
            @(negedge clk);
            if (monitor_on) begin
                check(!(prev_valid && res_valid), "R6 strobe width", int'(res_valid), 0);
                if (res_valid) begin
                    valid_seen++;
                    held_ev = res_events;
                    held_ck = res_clocks;
                    held_slow = res_slow;
                end else begin
                    check(res_events == held_ev, "R6 events held", int'(res_events), int'(held_ev));
                    check(res_clocks == held_ck, "R6 clocks held", int'(res_clocks), int'(held_ck));
                    check(res_slow == held_slow, "R6 mode held", int'(res_slow), int'(held_slow));
                end
                prev_valid = res_valid;
            end
        end
    end

    task automatic measure(input int per, input int hi, input bit extra_start, input string tag);
        int exp_slow, glen, exp_ev, exp_ck, waited, bound, v0;
        gen_per = per;
        gen_hi = hi;
        gen_ph = 0;
        repeat (per + 8) @(negedge clk);
        // R3: survey tally is about PRE_WIN/per; chosen periods sit far from THRESH
        exp_slow = ((PRE_WIN / per) < THRESH) ? 1 : 0;
        glen = exp_slow ? PER_GATE : FRQ_GATE;
        exp_ev = (glen + per - 1) / per;
        exp_ck = exp_ev * per;
        bound = PRE_WIN + (exp_ev + 1) * per + SYNC + 6;
        v0 = valid_seen;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!res_valid && waited < bound + 50) begin
            if (extra_start && waited == PRE_WIN + per + 20) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
            waited++;
        end
        start = 1'b0;
        check(res_valid == 1'b1, {"R8 result arrived ", tag}, int'(res_valid), 1);
        check(waited <= bound, {"R8 start-to-result ", tag}, waited, bound);
        check(int'(res_slow) == exp_slow, {"R3 mode ", tag}, int'(res_slow), exp_slow);
        check(int'(res_events) == exp_ev, {"R5 events ", tag}, int'(res_events), exp_ev);
        check(int'(res_clocks) == exp_ck, {"R4 clocks ", tag}, int'(res_clocks), exp_ck);
        @(negedge clk);
        check(res_valid == 1'b0, {"R6 strobe drop ", tag}, int'(res_valid), 0);
        check(valid_seen == v0 + 1, {"R6 one strobe ", tag}, valid_seen - v0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(res_valid == 1'b0, "R1 valid", int'(res_valid), 0);
        check(res_events == '0, "R1 events", int'(res_events), 0);
        check(res_clocks == '0, "R1 clocks", int'(res_clocks), 0);
        check(res_slow == 1'b0, "R1 mode", int'(res_slow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        monitor_on = 1'b1;
        // R2 idle with no start: nothing reported
        repeat (PRE_WIN + 100) @(negedge clk);
        check(valid_seen == 0, "R2 no start no result", valid_seen, 0);
        measure(7, 3, 1'b0, "fast p7");
        measure(25, 12, 1'b0, "gate exact p25");
        measure(10, 5, 1'b0, "gate exact p10");
        measure(50, 25, 1'b0, "slow p50");
        measure(100, 40, 1'b0, "slow p100");
        // R7 duty cycle has no effect
        measure(30, 1, 1'b0, "R7 narrow high");
        measure(30, 29, 1'b0, "R7 wide high");
        // R2 start while gate open is ignored
        measure(30, 15, 1'b1, "R2 busy start");
        repeat (PRE_WIN + 400) @(negedge clk);
        check(valid_seen == 8, "R2 no extra result", valid_seen, 8);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            vectors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule